// File: doc/BRIEF.md
# Signed Decimal Complement Adder

This block adds or subtracts two signed decimal numbers held as packed BCD words. Each word is one sign digit above D magnitude digits. Negative values are stored in 10's-complement form, so the whole word, sign digit included, behaves as one decimal number modulo 10^(D+1). Each digit pair is summed in binary and then corrected to decimal. The correction is applied to the sign digit as well, and the carry out of the sign digit is dropped.

A subtract control turns the second operand into its 10's complement first. Each of its digits is replaced by its 9's complement, and a carry of one enters the least significant digit. The arithmetic is combinational. The result, an overflow flag and a flag for illegal input codes are captured in output registers, so a result appears one clock after its operands.

Top module: `dec_tc_adder`

## Requirements
- R1: A word has D+1 digits of 4 bits, with digit 0 in bits [3:0] and the sign digit in bits [4D+3:4D]. The sign digit 4'h0 means plus and 4'h9 means minus. A value v in the range -10^D to 10^D-1 is coded as the decimal digits of v for v >= 0 and of 10^(D+1)+v for v < 0.
- R2: With sub low and valid inputs, the result is the coded word for A+B whenever that sum lies in range.
- R3: With sub high and valid inputs, the result is the coded word for A-B whenever that difference lies in range, including a subtrahend of -10^D.
- R4: For valid inputs every result digit, the sign digit included, is a legal BCD code from 0 to 9.
- R5: The carry out of the sign digit is discarded. For example, (+375)+(-240), given as 0375 and 9760, gives 0135.
- R6: The overflow flag is set exactly when the sign digit of A equals the sign digit of the effective second operand (B, or its complement under sub) and the result sign digit differs from it. That happens exactly when the true result is outside the range of R1. The result word is then the digit-wise sum of the coded words modulo 10^(D+1).
- R7: The invalid flag is set when any magnitude digit of A or B is above 9, or when either sign digit is neither 4'h0 nor 4'h9.
- R8: Outputs change only on a rising clock edge, one cycle after their inputs. A synchronous active-high reset clears the result and both flags to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 4*(D+1) | First operand, sign digit on top |
| opb | input | 4*(D+1) | Second operand, sign digit on top |
| sub | input | 1 | High to compute opa - opb |
| res | output | 4*(D+1) | Registered result word |
| ovf | output | 1 | Registered overflow flag |
| bad | output | 1 | Registered invalid-digit flag |

## Verification
On every cycle the assertions check these properties: reset clears the outputs, every digit a corrector produces from legal inputs is legal BCD, a registered result from valid inputs holds only decimal digits, and a result without overflow carries a sign of plus or minus. Only the bench's scenarios can show that the numeric value is right. The bench checks the sum and difference arithmetically over a grid of operands and over the range edges, including the lone value -10^D. It also checks that overflow is raised exactly when the true result leaves the range, and that each kind of illegal code raises the invalid flag.

// File: rtl/dta_pkg.sv
package dta_pkg;
  typedef logic [3:0] bcd_t;
  localparam bcd_t SIGN_PLUS  = 4'h0;
  localparam bcd_t SIGN_MINUS = 4'h9;
  localparam bcd_t DIGIT_MAX  = 4'h9;

  function automatic logic is_digit(input bcd_t d);
    return d <= DIGIT_MAX;
  endfunction

  function automatic logic is_sign(input bcd_t d);
    return (d == SIGN_PLUS) || (d == SIGN_MINUS);
  endfunction
endpackage

// File: rtl/dta_digit_add.sv
module dta_digit_add
  import dta_pkg::*;
(
  input  bcd_t x,
  input  bcd_t y,
  input  logic ci,
  output bcd_t s,
  output logic co
);
  logic [4:0] raw;

  always_comb begin
    raw = {1'b0, x} + {1'b0, y} + {4'b0, ci};
    co  = raw > 5'd9;
    s   = co ? (raw[3:0] + 4'd6) : raw[3:0];
  end

  // R4: a legal pair of digits always yields a legal digit
  always_comb begin
    if (is_digit(x) && is_digit(y))
      assert_digit_range_R4: assert (s <= DIGIT_MAX);
  end
endmodule

// File: rtl/dta_operand_prep.sv
module dta_operand_prep
  import dta_pkg::*;
#(
  parameter int ND = 4
) (
  input  logic [4*ND-1:0] b,
  input  logic            sub,
  output logic [4*ND-1:0] eff
);
  for (genvar i = 0; i < ND; i++) begin : g_dig
    bcd_t d;
    assign d = b[4*i +: 4];
    assign eff[4*i +: 4] = sub ? (DIGIT_MAX - d) : d;
  end
endmodule

// File: rtl/dta_digit_screen.sv
module dta_digit_screen
  import dta_pkg::*;
#(
  parameter int ND = 4
) (
  input  logic [4*ND-1:0] a,
  input  logic [4*ND-1:0] b,
  output logic            bad
);
  localparam int NM = ND - 1;
  logic [NM-1:0] bad_a, bad_b;

  for (genvar i = 0; i < NM; i++) begin : g_mag
    assign bad_a[i] = !is_digit(a[4*i +: 4]);
    assign bad_b[i] = !is_digit(b[4*i +: 4]);
  end

  assign bad = (|bad_a) || (|bad_b) ||
               !is_sign(a[4*NM +: 4]) || !is_sign(b[4*NM +: 4]);
endmodule

// File: rtl/dec_tc_adder.sv
module dec_tc_adder
  import dta_pkg::*;
#(
  parameter int D = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4*D+3:0]   opa,
  input  logic [4*D+3:0]   opb,
  input  logic             sub,
  output logic [4*D+3:0]   res,
  output logic             ovf,
  output logic             bad
);
  localparam int ND = D + 1;
  localparam int W  = 4 * ND;

  logic [W-1:0] beff;
  logic [W-1:0] sum_c;
  logic [ND:0]  carry;
  logic         bad_c, ovf_c;
  bcd_t         sa, sb, sr;

  dta_operand_prep #(.ND(ND)) u_prep (
    .b   (opb),
    .sub (sub),
    .eff (beff)
  );

  dta_digit_screen #(.ND(ND)) u_screen (
    .a   (opa),
    .b   (opb),
    .bad (bad_c)
  );

  assign carry[0] = sub;

  for (genvar i = 0; i < ND; i++) begin : g_add
    dta_digit_add u_dig (
      .x  (opa[4*i +: 4]),
      .y  (beff[4*i +: 4]),
      .ci (carry[i]),
      .s  (sum_c[4*i +: 4]),
      .co (carry[i+1])
    );
  end

  assign sa    = opa[W-1 -: 4];
  assign sb    = beff[W-1 -: 4];
  assign sr    = sum_c[W-1 -: 4];
  assign ovf_c = (sa == sb) && (sr != sa);

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
      ovf <= 1'b0;
      bad <= 1'b0;
    end else begin
      res <= sum_c;
      ovf <= ovf_c;
      bad <= bad_c;
    end
  end

  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> (res == '0 && !ovf && !bad));

  assert_sign_legal_R6: assert property (@(posedge clk) disable iff (rst)
    (!ovf && !bad) |-> (res[W-1 -: 4] == SIGN_PLUS || res[W-1 -: 4] == SIGN_MINUS));

  for (genvar i = 0; i < ND; i++) begin : g_chk
    assert_digits_bcd_R4: assert property (@(posedge clk) disable iff (rst)
      !bad |-> (res[4*i +: 4] <= DIGIT_MAX));
  end
endmodule

// File: tb/test_dec_tc_adder.sv
module test_dec_tc_adder;
  localparam int D   = 3;
  localparam int ND  = D + 1;
  localparam int W   = 4 * ND;
  localparam int LIM = 10 ** D;
  localparam int MOD = 10 ** ND;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0, opb = '0;
  logic         sub = 1'b0;
  logic [W-1:0] res;
  logic         ovf, bad;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dec_tc_adder #(.D(D)) i_dec_tc_adder (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .sub(sub),
    .res(res), .ovf(ovf), .bad(bad)
  );

  function automatic logic [W-1:0] to_bcd(input int u);
    logic [W-1:0] w = '0;
    int t = u;
    for (int i = 0; i < ND; i++) begin
      w[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return w;
  endfunction

  function automatic int code_of(input int v);
    return (v < 0) ? MOD + v : v;
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp,
                       input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic run(input int a, input int b, input logic s);
    int ca, cb, beff, raw, truev;
    logic eovf;
    ca = code_of(a);
    cb = code_of(b);
    beff = s ? (MOD - cb) % MOD : cb;
    raw = (ca + beff) % MOD;
    truev = s ? a - b : a + b;
    eovf = (truev < -LIM) || (truev > LIM - 1);
    opa = to_bcd(ca);
    opb = to_bcd(cb);
    sub = s;
    @(posedge clk);
    @(negedge clk);
    if (s) check("R3", res, to_bcd(raw), $sformatf("%0d-%0d", a, b));
    else   check("R2", res, to_bcd(raw), $sformatf("%0d+%0d", a, b));
    check("R6", W'(ovf), W'(eovf), $sformatf("ovf %0d %0d sub%0d", a, b, s));
    check("R7", W'(bad), W'(0), "valid operands");
  endtask

  task automatic run_raw(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                         input logic ebad, input string what);
    opa = a; opb = b; sub = s;
    @(posedge clk);
    @(negedge clk);
    check("R7", W'(bad), W'(ebad), what);
  endtask

  initial begin
    int edges [12] = '{-1000, -999, -998, -500, -1, 0, 1, 240, 499, 500, 998, 999};
    repeat (3) @(negedge clk);
    check("R8", res, '0, "reset result");
    check("R8", W'({ovf, bad}), W'(0), "reset flags");
    rst = 1'b0;
    // R5: stated example, end carry discarded
    run(375, -240, 1'b0);
    check("R5", res, to_bcd(135), "375 + -240");
    // R1: coding of -240 is 9760
    check("R1", to_bcd(code_of(-240)), W'(16'h9760), "coding");
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++) begin
        run(edges[i], edges[j], 1'b0);
        run(edges[i], edges[j], 1'b1);
      end
    for (int a = -1000; a < 1000; a += 13)
      for (int b = -1000; b < 1000; b += 11)
        run(a, b, 1'((a ^ b) & 1));
    // R7: illegal codes
    run_raw(16'h00A5, 16'h0001, 1'b0, 1'b1, "A digit 1010");
    run_raw(16'h0001, 16'h0F00, 1'b1, 1'b1, "B digit 1111");
    run_raw(16'h3001, 16'h0001, 1'b0, 1'b1, "A sign 0011");
    run_raw(16'h0001, 16'h1001, 1'b0, 1'b1, "B sign 0001");
    run_raw(16'h9999, 16'h0999, 1'b1, 1'b0, "legal extremes");
    // R8: synchronous reset clears outputs
    opa = 16'h0999; opb = 16'h0999; sub = 1'b0; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8", W'({ovf, bad}), W'(0), "reset after run");
    check("R8", res, '0, "reset after run result");
    done = 1;
  end

  initial begin
    for (int k = 0; k < 150000 && !done; k++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule